// File: doc/BRIEF.md
# Frame Capture Window Controller

This block decides which camera frames are allowed into a frame buffer. A host pulses a request to capture the next frame. The controller arms itself and waits for the next falling edge of the frame-sync input. At that edge it raises the buffer write enable. At the falling edge after that it lowers the write enable, drops busy and sets a completion flag.

The host learns that a capture has finished by pulsing a query input. The answer appears as a one-cycle acknowledge. A query made while a capture is in flight always answers "not yet". A query made when the block is idle answers with the completion flag and clears that flag in the same operation.

The block also counts rising edges of the line-valid input during each frame. At every falling edge of frame sync, it stores that count as the line total of the frame just ended. Frame sync and line valid can come from a different clock domain, so both pass through synchronizers before any edge is detected. Pixel data does not pass through this block.

Top module: `frame_capture_gate`

## Requirements
- R1: After reset, wr_en_o, busy_o, done_o and query_ack_o are 0 and last_lines_o is 0.
- R2: A request pulse sets busy_o on the next clock and arms a pending capture. It does not change wr_en_o.
- R3: At a synchronized falling edge of fsync_i with a capture pending, wr_en_o goes to 1, done_o goes to 0 and the pending request is consumed.
- R4: At a synchronized falling edge of fsync_i with nothing pending, wr_en_o goes to 0. If busy_o was 1, busy_o clears and done_o sets. If busy_o was 0, done_o is unchanged.
- R5: A query pulse produces query_ack_o one clock later, and the acknowledge lasts one cycle. While busy_o is 1 the acknowledge is 0 and done_o is kept. Otherwise the acknowledge equals done_o and done_o clears.
- R6: Each rising edge of lval_i increments a line counter. At each fsync_i falling edge the counter value moves to last_lines_o and the counter restarts from zero.
- R7: fsync_i and lval_i each pass through SYNC_STAGES flops (default 2). With the defaults, wr_en_o changes on the third rising clock edge after fsync_i falls, and not before.
- R8: A request in the same cycle that a frame-sync edge is acted on does not open wr_en_o at that edge. It opens wr_en_o at the following edge.
- R9: With SATURATE=1 (default), the line counter stops at 2**LINE_W-1. With LINE_W=10, a frame of 1030 lines reports 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, asynchronous; the falling edge marks a frame boundary |
| lval_i | input | 1 | Line valid, asynchronous; each rising edge counts as one line |
| req_i | input | 1 | One-cycle pulse: capture the next frame |
| query_i | input | 1 | One-cycle pulse: ask whether the capture has completed |
| wr_en_o | output | 1 | Frame buffer write enable |
| busy_o | output | 1 | A capture is requested or in progress |
| done_o | output | 1 | Completion flag, cleared by an accepted query |
| query_ack_o | output | 1 | One-cycle answer to a query |
| last_lines_o | output | LINE_W | Line count of the last completed frame |

## Verification
A pending request that is lost or duplicated inside the controller shows up at the very next frame-sync edge. In that case wr_en_o either fails to open or opens for an extra frame. A done flag stuck set or stuck clear shows up on the first query, one clock after the query pulse. A line counter that is not cleared shows up as a wrong last_lines_o at the second frame boundary. The directed sequences cross each of these points and sample right after the synchronizer delay, so an off-by-one stage count is also visible.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
   typedef struct packed {
      logic wen;
      logic busy;
      logic done;
      logic pend;
   } cap_state_t;

   localparam cap_state_t CAP_IDLE = '{wen: 1'b0, busy: 1'b0, done: 1'b0, pend: 1'b0};
endpackage

// File: rtl/fcg_sync_edge.sv
module fcg_sync_edge #(
   parameter int STAGES    = 2,
   parameter bit EDGE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic pulse_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fcg_sync_edge: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], async_i};
         prev_q  <= chain_q[LAST];
      end
   end

   if (EDGE_RISE) begin : g_rise
      assign pulse_o = chain_q[LAST] & ~prev_q;
   end else begin : g_fall
      assign pulse_o = ~chain_q[LAST] & prev_q;
   end
endmodule

// File: rtl/fcg_capture_fsm.sv
module fcg_capture_fsm
   import fcg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_edge_i,
   input  logic req_i,
   input  logic query_i,
   output logic wen_o,
   output logic busy_o,
   output logic done_o,
   output logic pend_o,
   output logic ack_o
);
   cap_state_t st_q, st_d;
   logic       ack_d, ack_q;

   always_comb begin
      st_d  = st_q;
      ack_d = 1'b0;
      // query reads the value held before this cycle's updates
      if (query_i && !st_q.busy) begin
         ack_d     = st_q.done;
         st_d.done = 1'b0;
      end
      if (frame_edge_i) begin
         if (st_q.pend) begin
            st_d.wen  = 1'b1;
            st_d.done = 1'b0;
            st_d.pend = 1'b0;
         end else begin
            st_d.wen = 1'b0;
            if (st_q.busy) begin
               st_d.busy = 1'b0;
               st_d.done = 1'b1;
            end
         end
      end
      // a request seen alongside an edge is kept for the next edge
      if (req_i) begin
         st_d.pend = 1'b1;
         st_d.busy = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CAP_IDLE;
         ack_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ack_q <= ack_d;
      end
   end

   assign wen_o  = st_q.wen;
   assign busy_o = st_q.busy;
   assign done_o = st_q.done;
   assign pend_o = st_q.pend;
   assign ack_o  = ack_q;
endmodule

// File: rtl/fcg_line_tally.sv
module fcg_line_tally #(
   parameter int LINE_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic              frame_edge_i,
   output logic [LINE_W-1:0] last_o
);
   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

   if (LINE_W < 1) begin : g_bad_width
      $error("fcg_line_tally: LINE_W must be positive");
   end

   logic [LINE_W-1:0] cnt_q, cnt_inc, last_q;

   if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
      end else if (frame_edge_i) begin
         last_q <= cnt_q;
         cnt_q  <= '0;
      end else if (line_i) begin
         cnt_q <= cnt_inc;
      end
   end

   assign last_o = last_q;
endmodule

// File: rtl/frame_capture_gate.sv
module frame_capture_gate #(
   parameter int LINE_W      = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic              lval_i,
   input  logic              req_i,
   input  logic              query_i,
   output logic              wr_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              query_ack_o,
   output logic [LINE_W-1:0] last_lines_o
);
   logic fs_fall;
   logic lv_rise;
   logic pend_w;

   fcg_sync_edge #(.STAGES(SYNC_STAGES), .EDGE_RISE(1'b0)) u_fs_edge (
      .clk(clk), .rst_n(rst_n), .async_i(fsync_i), .pulse_o(fs_fall)
   );

   fcg_sync_edge #(.STAGES(SYNC_STAGES), .EDGE_RISE(1'b1)) u_lv_edge (
      .clk(clk), .rst_n(rst_n), .async_i(lval_i), .pulse_o(lv_rise)
   );

   fcg_capture_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_edge_i(fs_fall), .req_i(req_i),
      .query_i(query_i), .wen_o(wr_en_o), .busy_o(busy_o), .done_o(done_o),
      .pend_o(pend_w), .ack_o(query_ack_o)
   );

   fcg_line_tally #(.LINE_W(LINE_W), .SATURATE(SATURATE)) u_tally (
      .clk(clk), .rst_n(rst_n), .line_i(lv_rise), .frame_edge_i(fs_fall),
      .last_o(last_lines_o)
   );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
   parameter int LINE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fs_fall,
   input logic              pend,
   input logic              req_i,
   input logic              query_i,
   input logic              wr_en_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              query_ack_o,
   input logic [LINE_W-1:0] last_lines_o
);
   a_r2_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> busy_o);

   a_r3_open_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_fall && pend) |=> (wr_en_o && !done_o));

   a_r4_close_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_fall && !pend) |=> !wr_en_o);

   a_r4_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_fall && !pend && busy_o && !req_i) |=> (done_o && !busy_o));

   a_r5_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (query_i && busy_o) |=> !query_ack_o);

   a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      query_ack_o |=> !query_ack_o);

   a_r6_last_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_fall |=> $stable(last_lines_o));

   a_r3_wen_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_fall |=> $stable(wr_en_o));

   a_r2_wen_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o);
endmodule

bind frame_capture_gate fcg_checker #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fs_fall(fs_fall), .pend(pend_w),
   .req_i(req_i), .query_i(query_i), .wr_en_o(wr_en_o), .busy_o(busy_o),
   .done_o(done_o), .query_ack_o(query_ack_o), .last_lines_o(last_lines_o)
);

// File: tb/frame_capture_gate_tb.sv
module frame_capture_gate_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsync_i = 1'b1, lval_i = 1'b0, req_i = 1'b0, query_i = 1'b0;
   logic wr_en_o, busy_o, done_o, query_ack_o;
   logic [LW-1:0] last_lines_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_capture_gate #(.LINE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .lval_i(lval_i),
      .req_i(req_i), .query_i(query_i), .wr_en_o(wr_en_o), .busy_o(busy_o),
      .done_o(done_o), .query_ack_o(query_ack_o), .last_lines_o(last_lines_o)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_req();
      @(negedge clk) req_i = 1'b1;
      @(negedge clk) req_i = 1'b0;
   endtask

   task automatic do_query(output logic ack);
      @(negedge clk) query_i = 1'b1;
      @(negedge clk) query_i = 1'b0;
      ack = query_ack_o;
   endtask

   task automatic lines(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) lval_i = 1'b1;
         repeat (3) @(negedge clk);
         lval_i = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic frame_edge();
      @(negedge clk) fsync_i = 1'b1;
      repeat (4) @(negedge clk);
      fsync_i = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 wr_en", wr_en_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 ack", query_ack_o, 0);
      chk("R1 last_lines", last_lines_o, 0);
   endtask

   task automatic t_full_capture();
      logic ack;
      frame_edge();                       // idle edge clears the reset-time count
      chk("R4 idle edge keeps done", done_o, 0);
      do_req();
      chk("R2 busy after request", busy_o, 1);
      chk("R2 wr_en unchanged", wr_en_o, 0);
      do_query(ack);
      chk("R5 ack while busy", ack, 0);
      lines(5);
      frame_edge();
      chk("R3 wr_en opens", wr_en_o, 1);
      chk("R3 done clear", done_o, 0);
      chk("R6 last_lines frame A", last_lines_o, 5);
      lines(7);
      frame_edge();
      chk("R4 wr_en closes", wr_en_o, 0);
      chk("R4 busy clears", busy_o, 0);
      chk("R4 done sets", done_o, 1);
      chk("R6 last_lines frame B", last_lines_o, 7);
      do_query(ack);
      chk("R5 ack idle done", ack, 1);
      chk("R5 done cleared by query", done_o, 0);
      do_query(ack);
      chk("R5 second query", ack, 0);
      frame_edge();
      chk("R6 empty frame", last_lines_o, 0);
      chk("R4 edge idle wr_en", wr_en_o, 0);
   endtask

   task automatic t_sync_delay();
      do_req();
      fsync_i = 1'b1;
      repeat (4) @(negedge clk);
      fsync_i = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R7 wr_en not yet after two edges", wr_en_o, 0);
      @(negedge clk);
      chk("R7 wr_en after third edge", wr_en_o, 1);
      frame_edge();
      chk("R7 close", wr_en_o, 0);
   endtask

   task automatic t_same_cycle();
      logic ack;
      do_query(ack);                      // clear done left by previous capture
      @(negedge clk) fsync_i = 1'b1;
      repeat (4) @(negedge clk);
      fsync_i = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk) req_i = 1'b1;        // present on the edge that acts
      @(negedge clk) req_i = 1'b0;
      chk("R8 wr_en stays closed", wr_en_o, 0);
      chk("R8 busy set", busy_o, 1);
      frame_edge();
      chk("R8 opens at following edge", wr_en_o, 1);
      frame_edge();
      chk("R8 closes", wr_en_o, 0);
      chk("R8 done", done_o, 1);
   endtask

   task automatic t_saturate();
      frame_edge();
      lines(1030);
      frame_edge();
      chk("R9 saturated count", last_lines_o, 1023);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_capture();
      t_sync_delay();
      t_same_cycle();
      t_saturate();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule